// File: doc/BRIEF.md
# Vector Operation Command Front-End

This block is the host-facing control block of a big-number arithmetic coprocessor. A host programs four vector pointer registers, two vector length registers, a shift-count register and a function register over a simple register bus. It then starts a basic operation by writing the function register with the run bit set. The block checks that exactly one operation is selected and latches the operand set for the run. It then gives a one-cycle start pulse, the decoded operation and the operands to the execution unit.

While an operation runs, the pointer and length registers act as the buffer for the next operation. The operation field, the run bit and the shift count are locked. The execution unit reports completion with a done pulse that carries the compare flags and the two most-significant-word results. The block commits these results and clears the run bit. If the host has set the stall-result bit, the block holds the results and the run-bit clear until the host writes stall-result back to zero. The completion interrupt is the complement of the run bit. Register reads are combinational and always return the live values, and the bus never stalls.

Top module: `vec_cmd_frontend`

## Requirements
- R1: After reset every readable register reads zero, `irq_o` is 1, and both `err_o` and `exec_start_o` are 0.
- R2: The register map is: pointers at addresses 0 to 3, lengths at 4 and 5, shift count at 6, function at 7, compare result at 8, word result at 9 and remainder result at 10. A pointer stores 11 bits with bit 0 forced to zero. A length stores 9 bits and the shift count stores 5 bits. Upper bits read as zero.
- R3: The function register has the operation field at bits [11:0], run at bit 15, error at bit 16 and stall-result at bit 24. The operation bits are 0, 1 and 4 to 11, and bit 3 is a modifier that is not counted as an operation. A write with run=1 while idle and exactly one operation bit set starts an operation: run reads 1, `irq_o` drops to 0, `exec_op_o` shows bits [11:0], and `exec_start_o` is high for exactly the one cycle after the write edge.
- R4: A write with run=1 while idle and zero or several operation bits set starts nothing. Run stays 0, `exec_start_o` stays 0, and `err_o` and function bit 16 read 1 until the next valid start.
- R5: Pointer and length writes are readable at once. The execution-side outputs `exec_*ptr_o` and `exec_*len_o` keep the values latched at the last start until the next start.
- R6: While running, writes to function bits [11:0], to the run bit and to the shift count are ignored.
- R7: A done pulse while running with stall-result 0 updates the compare (bits [2:0]), word-result and remainder-result registers and clears run on the same edge, so `irq_o` returns to 1.
- R8: With stall-result 1, a done pulse leaves run at 1 and the result registers unchanged. On the write edge that clears stall-result nothing changes yet. On the following edge the results held from the done pulse are committed and run clears.
- R9: A done pulse while idle changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (4) | Register word address, for reads and writes |
| reg_wdata_i | input | DW (32) | Write data |
| reg_rdata_o | output | DW (32) | Combinational read data for `reg_addr_i` |
| exec_start_o | output | 1 | One-cycle start pulse to the execution unit |
| exec_op_o | output | 12 | Operation field of the function register |
| exec_aptr_o | output | PTR_W (11) | Pointer A of the running operation |
| exec_bptr_o | output | PTR_W (11) | Pointer B of the running operation |
| exec_cptr_o | output | PTR_W (11) | Pointer C of the running operation |
| exec_dptr_o | output | PTR_W (11) | Pointer D of the running operation |
| exec_alen_o | output | LEN_W (9) | Length A of the running operation |
| exec_blen_o | output | LEN_W (9) | Length B of the running operation |
| exec_shift_o | output | SH_W (5) | Shift count |
| exec_done_i | input | 1 | Completion pulse from the execution unit |
| exec_cmp_i | input | 3 | Compare flags {greater, less, equal} |
| exec_msw_i | input | 16 | Word-result report |
| exec_divmsw_i | input | 16 | Remainder-result report |
| irq_o | output | 1 | Completion interrupt, complement of run |
| err_o | output | 1 | Invalid-start flag |

## Verification
The hardest case to reach is the stalled completion. The done pulse has to arrive while stall-result is set, the execution unit's result inputs have to change afterwards, and the release write has to be observed on two separate edges. The bench drives new random result values after the stalled done pulse. This proves that the held copy and not the live input is committed. It then reads run both right after the release write and one cycle later. Double buffering is reached by writing operands between the start and the done pulse, and by comparing the execution-side outputs with the latched set rather than the readable one.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  localparam int OP_W      = 12;
  localparam logic [OP_W-1:0] OP_MASK = 12'hFF3;
  localparam int BIT_RUN   = 15;
  localparam int BIT_ERR   = 16;
  localparam int BIT_STALL = 24;
  localparam int CMP_W     = 3;
  localparam int RES_W     = 16;
  localparam int NPTR      = 4;
  localparam int NLEN      = 2;
  localparam int ADDR_PTR0 = 0;
  localparam int ADDR_LEN0 = ADDR_PTR0 + NPTR;
  localparam int ADDR_SHIFT  = ADDR_LEN0 + NLEN;
  localparam int ADDR_FUNC   = ADDR_SHIFT + 1;
  localparam int ADDR_CMP    = ADDR_FUNC + 1;
  localparam int ADDR_MSW    = ADDR_CMP + 1;
  localparam int ADDR_DIVMSW = ADDR_MSW + 1;

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic [RES_W-1:0] msw;
    logic [RES_W-1:0] divmsw;
  } res_t;

  function automatic logic single_op(logic [OP_W-1:0] ops);
    return $countones(ops & OP_MASK) == 1;
  endfunction
endpackage

// File: rtl/vcf_operand_bank.sv
module vcf_operand_bank #(
  parameter int PTR_W = 11,
  parameter int LEN_W = 9,
  parameter int NP    = 4,
  parameter int NL    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             ptr_wr_i,
  input  logic [NL-1:0]             len_wr_i,
  input  logic [PTR_W-1:1]          ptr_wdata_i,
  input  logic [LEN_W-1:0]          len_wdata_i,
  input  logic                      load_i,
  output logic [NP-1:0][PTR_W-1:0]  ptr_nxt_o,
  output logic [NP-1:0][PTR_W-1:0]  ptr_cur_o,
  output logic [NL-1:0][LEN_W-1:0]  len_nxt_o,
  output logic [NL-1:0][LEN_W-1:0]  len_cur_o
);
  for (genvar g = 0; g < NP; g++) begin : g_ptr
    logic [PTR_W-1:0] nxt_q, cur_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nxt_q <= '0;
        cur_q <= '0;
      end else begin
        if (ptr_wr_i[g]) nxt_q <= {ptr_wdata_i, 1'b0};
        if (load_i)      cur_q <= nxt_q;
      end
    end
    assign ptr_nxt_o[g] = nxt_q;
    assign ptr_cur_o[g] = cur_q;
  end

  for (genvar g = 0; g < NL; g++) begin : g_len
    logic [LEN_W-1:0] nxt_q, cur_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nxt_q <= '0;
        cur_q <= '0;
      end else begin
        if (len_wr_i[g]) nxt_q <= len_wdata_i;
        if (load_i)      cur_q <= nxt_q;
      end
    end
    assign len_nxt_o[g] = nxt_q;
    assign len_cur_o[g] = cur_q;
  end

  // R5: execution-side operand set only moves on a start
  a_r5_cur_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ptr_cur_o) && $stable(len_cur_o));
endmodule

// File: rtl/vcf_func_ctrl.sv
module vcf_func_ctrl
  import vcf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            func_wr_i,
  input  logic            shift_wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            done_i,
  output logic            run_o,
  output logic            stall_o,
  output logic            err_o,
  output logic            pend_o,
  output logic [OP_W-1:0] ops_o,
  output logic [SH_W-1:0] shift_o,
  output logic            start_o,
  output logic            load_o,
  output logic            capture_o,
  output logic            commit_o
);
  logic run_q, stall_q, err_q, pend_q, start_q;
  logic [OP_W-1:0] ops_q;
  logic [SH_W-1:0] shift_q;
  logic go, ok, done_act;

  always_comb begin
    go        = func_wr_i && wdata_i[BIT_RUN] && !run_q;
    ok        = single_op(wdata_i[OP_W-1:0]);
    load_o    = go && ok;
    done_act  = run_q && done_i && !pend_q;
    capture_o = done_act && stall_q;
    commit_o  = run_q && !stall_q && (pend_q || done_act);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      stall_q <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      ops_q   <= '0;
      shift_q <= '0;
    end else begin
      if (func_wr_i) begin
        stall_q <= wdata_i[BIT_STALL];
        if (!run_q) ops_q <= wdata_i[OP_W-1:0];
      end
      if (go) err_q <= !ok;
      if (load_o)        run_q <= 1'b1;
      else if (commit_o) run_q <= 1'b0;
      if (capture_o)     pend_q <= 1'b1;
      else if (commit_o) pend_q <= 1'b0;
      start_q <= load_o;
      if (shift_wr_i && !run_q) shift_q <= wdata_i[SH_W-1:0];
    end
  end

  assign run_o   = run_q;
  assign stall_o = stall_q;
  assign err_o   = err_q;
  assign pend_o  = pend_q;
  assign ops_o   = ops_q;
  assign shift_o = shift_q;
  assign start_o = start_q;

  // R3: a start pulse only goes out for a running single-operation command
  a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> run_q && ($countones(ops_q & OP_MASK) == 1));
  // R4: an error flag never coexists with a run
  a_r4_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !run_q);
  // R6: operation field and shift count frozen across a run
  a_r6_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) |-> $stable(ops_q) && $stable(shift_q));
  // R7: run only falls after a done pulse or a held completion
  a_r7_run_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(done_i) || $past(pend_q));
  // R8: a held result keeps the operation running
  a_r8_pend_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> run_q);
endmodule

// File: rtl/vcf_result_regs.sv
module vcf_result_regs
  import vcf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  res_t res_i,
  input  logic capture_i,
  input  logic commit_i,
  input  logic use_hold_i,
  output res_t res_o
);
  res_t hold_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (capture_i) hold_q <= res_i;
      if (commit_i)  out_q  <= use_hold_i ? hold_q : res_i;
    end
  end

  assign res_o = out_q;

  // R9: visible results change only on a commit
  a_r9_res_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(out_q));
  // R8: commit and capture never coincide
  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_i && commit_i));
endmodule

// File: rtl/vec_cmd_frontend.sv
module vec_cmd_frontend
  import vcf_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int PTR_W = 11,
  parameter int LEN_W = 9,
  parameter int SH_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              exec_start_o,
  output logic [OP_W-1:0]   exec_op_o,
  output logic [PTR_W-1:0]  exec_aptr_o,
  output logic [PTR_W-1:0]  exec_bptr_o,
  output logic [PTR_W-1:0]  exec_cptr_o,
  output logic [PTR_W-1:0]  exec_dptr_o,
  output logic [LEN_W-1:0]  exec_alen_o,
  output logic [LEN_W-1:0]  exec_blen_o,
  output logic [SH_W-1:0]   exec_shift_o,
  input  logic              exec_done_i,
  input  logic [CMP_W-1:0]  exec_cmp_i,
  input  logic [RES_W-1:0]  exec_msw_i,
  input  logic [RES_W-1:0]  exec_divmsw_i,
  output logic              irq_o,
  output logic              err_o
);
  logic [NPTR-1:0] ptr_wr;
  logic [NLEN-1:0] len_wr;
  logic func_wr, shift_wr;
  logic [NPTR-1:0][PTR_W-1:0] ptr_nxt, ptr_cur;
  logic [NLEN-1:0][LEN_W-1:0] len_nxt, len_cur;
  logic run, stall, err, pend, load, capture, commit;
  logic [OP_W-1:0] ops;
  logic [SH_W-1:0] shift;
  res_t res_in, res_out;

  always_comb begin
    for (int i = 0; i < NPTR; i++) ptr_wr[i] = reg_wr_i && (reg_addr_i == AW'(ADDR_PTR0 + i));
    for (int i = 0; i < NLEN; i++) len_wr[i] = reg_wr_i && (reg_addr_i == AW'(ADDR_LEN0 + i));
    shift_wr = reg_wr_i && (reg_addr_i == AW'(ADDR_SHIFT));
    func_wr  = reg_wr_i && (reg_addr_i == AW'(ADDR_FUNC));
  end

  vcf_operand_bank #(.PTR_W(PTR_W), .LEN_W(LEN_W), .NP(NPTR), .NL(NLEN)) u_bank (
    .clk_i, .rst_ni,
    .ptr_wr_i(ptr_wr), .len_wr_i(len_wr),
    .ptr_wdata_i(reg_wdata_i[PTR_W-1:1]), .len_wdata_i(reg_wdata_i[LEN_W-1:0]),
    .load_i(load),
    .ptr_nxt_o(ptr_nxt), .ptr_cur_o(ptr_cur),
    .len_nxt_o(len_nxt), .len_cur_o(len_cur)
  );

  vcf_func_ctrl #(.DW(DW), .SH_W(SH_W)) u_ctrl (
    .clk_i, .rst_ni,
    .func_wr_i(func_wr), .shift_wr_i(shift_wr), .wdata_i(reg_wdata_i),
    .done_i(exec_done_i),
    .run_o(run), .stall_o(stall), .err_o(err), .pend_o(pend),
    .ops_o(ops), .shift_o(shift), .start_o(exec_start_o),
    .load_o(load), .capture_o(capture), .commit_o(commit)
  );

  assign res_in = '{cmp: exec_cmp_i, msw: exec_msw_i, divmsw: exec_divmsw_i};

  vcf_result_regs u_res (
    .clk_i, .rst_ni,
    .res_i(res_in), .capture_i(capture), .commit_i(commit),
    .use_hold_i(pend), .res_o(res_out)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NPTR; i++)
      if (reg_addr_i == AW'(ADDR_PTR0 + i)) reg_rdata_o = DW'(ptr_nxt[i]);
    for (int i = 0; i < NLEN; i++)
      if (reg_addr_i == AW'(ADDR_LEN0 + i)) reg_rdata_o = DW'(len_nxt[i]);
    if (reg_addr_i == AW'(ADDR_SHIFT)) reg_rdata_o = DW'(shift);
    if (reg_addr_i == AW'(ADDR_FUNC)) begin
      reg_rdata_o[OP_W-1:0] = ops;
      reg_rdata_o[BIT_RUN]   = run;
      reg_rdata_o[BIT_ERR]   = err;
      reg_rdata_o[BIT_STALL] = stall;
    end
    if (reg_addr_i == AW'(ADDR_CMP))    reg_rdata_o = DW'(res_out.cmp);
    if (reg_addr_i == AW'(ADDR_MSW))    reg_rdata_o = DW'(res_out.msw);
    if (reg_addr_i == AW'(ADDR_DIVMSW)) reg_rdata_o = DW'(res_out.divmsw);
  end

  assign exec_op_o    = ops;
  assign exec_aptr_o  = ptr_cur[0];
  assign exec_bptr_o  = ptr_cur[1];
  assign exec_cptr_o  = ptr_cur[2];
  assign exec_dptr_o  = ptr_cur[3];
  assign exec_alen_o  = len_cur[0];
  assign exec_blen_o  = len_cur[1];
  assign exec_shift_o = shift;
  assign irq_o        = !run;
  assign err_o        = err;

  // R3: a start pulse drops the interrupt line
  a_r3_start_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> !irq_o);
  // R7: a done pulse without stall ends the run
  a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && exec_done_i && !stall && !pend |=> irq_o);
endmodule

// File: tb/vec_cmd_frontend_tb_top.sv
module vec_cmd_frontend_tb_top;
  localparam int AW = 4, DW = 32;
  localparam int A_SHIFT = 6, A_FUNC = 7, A_CMP = 8, A_MSW = 9, A_DIV = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic reg_wr_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic exec_start_o, exec_done_i = 1'b0, irq_o, err_o;
  logic [11:0] exec_op_o;
  logic [10:0] exec_aptr_o, exec_bptr_o, exec_cptr_o, exec_dptr_o;
  logic [8:0] exec_alen_o, exec_blen_o;
  logic [4:0] exec_shift_o;
  logic [2:0] exec_cmp_i = '0;
  logic [15:0] exec_msw_i = '0, exec_divmsw_i = '0;

  vec_cmd_frontend dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [10:0] m_ptr [4], c_ptr [4];
  logic [8:0] m_len [2], c_len [2];
  logic [4:0] m_shift;
  logic [11:0] m_ops;
  bit m_stall, m_err, m_run;
  logic [2:0] m_cmp;
  logic [15:0] m_msw, m_div;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fn_func(bit stall, bit err, bit run, logic [11:0] ops);
    logic [31:0] w = '0;
    w[11:0] = ops; w[15] = run; w[16] = err; w[24] = stall;
    return w;
  endfunction

  function automatic bit fn_valid(logic [11:0] ops);
    return $countones(ops & 12'hFF3) == 1;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = AW'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr_i = AW'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin rd(i, d); chk(tag, d, {21'b0, m_ptr[i]}); end
    for (int i = 0; i < 2; i++) begin rd(4 + i, d); chk(tag, d, {23'b0, m_len[i]}); end
    rd(A_SHIFT, d); chk(tag, d, {27'b0, m_shift});
    rd(A_FUNC, d);  chk(tag, d, fn_func(m_stall, m_err, m_run, m_ops));
    rd(A_CMP, d);   chk(tag, d, {29'b0, m_cmp});
    rd(A_MSW, d);   chk(tag, d, {16'b0, m_msw});
    rd(A_DIV, d);   chk(tag, d, {16'b0, m_div});
    chk(tag, irq_o, !m_run);
    chk(tag, err_o, m_err);
  endtask

  task automatic check_exec(string tag);
    chk(tag, {exec_aptr_o, exec_bptr_o, exec_cptr_o, exec_dptr_o},
        {c_ptr[0], c_ptr[1], c_ptr[2], c_ptr[3]});
    chk(tag, {exec_alen_o, exec_blen_o}, {c_len[0], c_len[1]});
    chk(tag, exec_shift_o, m_shift);
    chk(tag, exec_op_o, m_ops);
  endtask

  task automatic set_operands();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin d = $urandom; wr(i, d); m_ptr[i] = d[10:0] & 11'h7FE; end
    for (int i = 0; i < 2; i++) begin d = $urandom; wr(4 + i, d); m_len[i] = d[8:0]; end
    d = $urandom; wr(A_SHIFT, d); m_shift = d[4:0];
  endtask

  task automatic start(logic [11:0] ops, bit stall);
    bit v = fn_valid(ops);
    wr(A_FUNC, fn_func(stall, 1'b0, 1'b1, ops));
    m_stall = stall; m_ops = ops;
    if (v) begin m_err = 0; m_run = 1; c_ptr = m_ptr; c_len = m_len; end
    else m_err = 1;
    chk(v ? "R3 start pulse" : "R4 no start", exec_start_o, v);
    if (v) check_exec("R3 exec view");
    @(negedge clk_i);
    chk("R3 single pulse", exec_start_o, 1'b0);
  endtask

  task automatic drive_results();
    exec_cmp_i = 3'($urandom); exec_msw_i = 16'($urandom); exec_divmsw_i = 16'($urandom);
  endtask

  task automatic done_pulse();
    @(negedge clk_i); exec_done_i = 1'b1;
    @(negedge clk_i); exec_done_i = 1'b0;
  endtask

  task automatic finish_op(bit stall);
    logic [31:0] d;
    logic [2:0] h_cmp; logic [15:0] h_msw, h_div;
    drive_results();
    h_cmp = exec_cmp_i; h_msw = exec_msw_i; h_div = exec_divmsw_i;
    done_pulse();
    if (!stall) begin
      m_run = 0; m_cmp = h_cmp; m_msw = h_msw; m_div = h_div;
      check_regs("R7 commit");
    end else begin
      drive_results();
      check_regs("R8 held");
      wr(A_FUNC, fn_func(1'b0, 1'b0, 1'b0, 12'h0));
      m_stall = 0;
      rd(A_FUNC, d);
      chk("R8 release edge", d[15], 1'b1);
      @(negedge clk_i);
      m_run = 0; m_cmp = h_cmp; m_msw = h_msw; m_div = h_div;
      check_regs("R8 commit");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] ops;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin m_ptr[i] = '0; c_ptr[i] = '0; end
    for (int i = 0; i < 2; i++) begin m_len[i] = '0; c_len[i] = '0; end
    m_shift = '0; m_ops = '0; m_stall = 0; m_err = 0; m_run = 0;
    m_cmp = '0; m_msw = '0; m_div = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_regs("R1 reset");
    chk("R1 start idle", exec_start_o, 1'b0);

    wr(0, 32'hFFFF_FFFF); m_ptr[0] = 11'h7FE;
    wr(4, 32'hFFFF_FFFF); m_len[0] = 9'h1FF;
    wr(A_SHIFT, 32'hFFFF_FFFF); m_shift = 5'h1F;
    wr(11, 32'hFFFF_FFFF);
    check_regs("R2 widths");

    start(12'h011, 1'b0); check_regs("R4 two ops");
    start(12'h000, 1'b0); check_regs("R4 no op");
    start(12'h008, 1'b0); check_regs("R4 modifier only");

    set_operands();
    start(12'h018, 1'b0);
    check_regs("R3 running");
    d = $urandom; wr(0, d); m_ptr[0] = d[10:0] & 11'h7FE;
    d = $urandom; wr(5, d); m_len[1] = d[8:0];
    wr(A_SHIFT, 32'h3);
    wr(A_FUNC, fn_func(1'b0, 1'b0, 1'b1, 12'h001));
    check_regs("R6 locked");
    check_exec("R5 buffered");
    finish_op(1'b0);
    check_exec("R5 after done");

    drive_results();
    done_pulse();
    check_regs("R9 idle done");

    start(12'h040, 1'b0);
    check_exec("R5 next start");
    finish_op(1'b0);

    start(12'h400, 1'b1);
    finish_op(1'b1);

    for (int it = 0; it < 60; it++) begin
      int p;
      bit st;
      set_operands();
      p = $urandom % 10; ops = 12'(1) << (p < 2 ? p : p + 2);
      if ($urandom % 4 == 0) begin p = $urandom % 10; ops |= 12'(1) << (p < 2 ? p : p + 2); end
      if ($urandom % 2 == 0) ops |= 12'h008;
      st = ($urandom % 3 == 0);
      start(ops, st);
      if (!m_run) begin check_regs("R4 random"); continue; end
      if ($urandom % 2 == 0) begin
        d = $urandom; wr(3, d); m_ptr[3] = d[10:0] & 11'h7FE;
        check_exec("R5 random");
      end
      finish_op(st);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule